// File: doc/BRIEF.md
# Prefix-Driven I/O Space Redirector

This block sits between the instruction decoder and the external bus. It has no I/O opcodes of its own. Instead, the decoder pulses one of two prefix-detect lines when it meets a one-byte prefix. The pulse arms a space latch, and every memory access that the following instruction issues is steered to the selected I/O space instead of memory. One prefix selects the on-chip peripheral register space. The other selects the off-chip I/O space. The latch falls back to memory at the next instruction boundary.

Each access request carries a 16-bit effective address, a direction flag and write data. Address and data travel to the bus unchanged. The only thing the block decides is which of three strobe pairs (memory, internal I/O, external I/O) fires, one cycle after the request. A word access is made of two consecutive requests inside one instruction, so both halves land in the same space. A write into the internal space is privileged. The block raises an interrupt-hold line so that no interrupt can be accepted at the boundary that follows that instruction.

Top module: `io_space_redirector`

## Requirements
- R1: While reset is applied, and after it is released, no strobe is active and irq_hold_o is low. The first access after reset goes to memory.
- R2: With no prefix armed, a request raises mem_rd_o (req_we_i=0) or mem_wr_o (req_we_i=1) in the cycle after the request, and all I/O strobes stay low.
- R3: A pfx_int_i pulse arms the internal space. Requests from the next cycle on raise ioi_rd_o or ioi_wr_o.
- R4: A pfx_ext_i pulse arms the external space. Requests from the next cycle on raise ioe_rd_o or ioe_wr_o.
- R5: An insn_end_i pulse disarms the latch, and later requests go to memory. A prefix pulse in the same cycle as insn_end_i takes precedence and stays armed.
- R6: All requests issued between a prefix and the next boundary go to the same space. A two-part word access therefore reads two consecutive I/O locations.
- R7: If both prefixes arrive before one instruction, the later one selects the space. If they arrive in the same cycle, the external space wins.
- R8: Each request yields exactly one active strobe, one cycle later. A cycle with no request yields no strobe.
- R9: bus_addr_o and bus_wdata_o equal the request's address and data in the strobe cycle. An I/O address is the plain effective address.
- R10: irq_hold_o is high in the cycle of an internal-space write and stays high through the next insn_end_i cycle, inclusive. It is low otherwise. External writes and internal reads do not raise it.
- R11: A request in the same cycle as insn_end_i still uses the space that was armed, because it belongs to the instruction that is ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfx_int_i | input | 1 | Pulse: internal-space prefix decoded |
| pfx_ext_i | input | 1 | Pulse: external-space prefix decoded |
| insn_end_i | input | 1 | Pulse: current instruction completes this cycle |
| req_valid_i | input | 1 | Access request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Effective address |
| req_wdata_i | input | 8 | Write data |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| ioi_rd_o | output | 1 | Internal I/O read strobe |
| ioi_wr_o | output | 1 | Internal I/O write strobe |
| ioe_rd_o | output | 1 | External I/O read strobe |
| ioe_wr_o | output | 1 | External I/O write strobe |
| bus_addr_o | output | 16 | Registered access address |
| bus_wdata_o | output | 8 | Registered write data |
| irq_hold_o | output | 1 | Interrupt acceptance must be held off |

## Verification
The hardest case to reach is an instruction boundary that coincides with other events. The stimulus makes it coincide with the last half of a prefixed word read, then with a fresh prefix pulse, and then with a privileged internal write. In each of these cases both the strobe that fires and the one-cycle window of irq_hold_o depend on precedence inside one clock. The stimulus also sends both prefixes in one cycle and in consecutive cycles to separate the two tie rules. A reference model in the bench tracks the armed space and the hold state on its own, and a scoreboard matches every strobe cycle against the queued expectation.

// File: rtl/redir_pkg.sv
package redir_pkg;
  typedef enum logic [1:0] {
    SPC_MEM = 2'd0,
    SPC_INT = 2'd1,
    SPC_EXT = 2'd2
  } space_e;

  localparam int NUM_SPACES = 3;
endpackage

// File: rtl/redir_rst_sync.sv
module redir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/redir_prefix_latch.sv
module redir_prefix_latch
  import redir_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pfx_int,
  input  logic   pfx_ext,
  input  logic   insn_end,
  output space_e space_o
);
  space_e space_q;
  space_e space_d;
  logic   space_en;

  // A prefix outranks the boundary; external outranks internal on a tie.
  always_comb begin
    space_en = pfx_int | pfx_ext | insn_end;
    if (pfx_ext)      space_d = SPC_EXT;
    else if (pfx_int) space_d = SPC_INT;
    else              space_d = SPC_MEM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        space_q <= SPC_MEM;
    else if (space_en) space_q <= space_d;
  end

  assign space_o = space_q;
endmodule

// File: rtl/redir_priv_guard.sv
module redir_priv_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic int_wr,
  input  logic insn_end,
  output logic hold_o
);
  logic hold_q;
  logic hold_d;

  always_comb begin
    if (insn_end)    hold_d = 1'b0;
    else if (int_wr) hold_d = 1'b1;
    else             hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  // The current write itself must already block the boundary it shares.
  assign hold_o = hold_q | int_wr;
endmodule

// File: rtl/redir_strobe_gen.sv
module redir_strobe_gen
  import redir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_we,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  space_e                space_i,
  output logic [NUM_SPACES-1:0] rd_o,
  output logic [NUM_SPACES-1:0] wr_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [DATA_W-1:0]     wdata_o
);
  logic [NUM_SPACES-1:0] rd_d, rd_q;
  logic [NUM_SPACES-1:0] wr_d, wr_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [DATA_W-1:0]     wdata_q;

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
    logic hit;
    always_comb begin
      hit     = req_valid && (space_i == space_e'(s));
      rd_d[s] = hit && !req_we;
      wr_d[s] = hit &&  req_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_valid) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign rd_o    = rd_q;
  assign wr_o    = wr_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/io_space_redirector.sv
module io_space_redirector
  import redir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfx_int_i,
  input  logic              pfx_ext_i,
  input  logic              insn_end_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              ioi_rd_o,
  output logic              ioi_wr_o,
  output logic              ioe_rd_o,
  output logic              ioe_wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              irq_hold_o
);
  logic                  rst_sync_n;
  space_e                space_cur;
  logic                  int_wr;
  logic [NUM_SPACES-1:0] rd_vec;
  logic [NUM_SPACES-1:0] wr_vec;

  redir_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  redir_prefix_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pfx_int  (pfx_int_i),
    .pfx_ext  (pfx_ext_i),
    .insn_end (insn_end_i),
    .space_o  (space_cur)
  );

  assign int_wr = req_valid_i && req_we_i && (space_cur == SPC_INT);

  redir_priv_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .int_wr   (int_wr),
    .insn_end (insn_end_i),
    .hold_o   (irq_hold_o)
  );

  redir_strobe_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid_i),
    .req_we    (req_we_i),
    .req_addr  (req_addr_i),
    .req_wdata (req_wdata_i),
    .space_i   (space_cur),
    .rd_o      (rd_vec),
    .wr_o      (wr_vec),
    .addr_o    (bus_addr_o),
    .wdata_o   (bus_wdata_o)
  );

  assign mem_rd_o = rd_vec[SPC_MEM];
  assign mem_wr_o = wr_vec[SPC_MEM];
  assign ioi_rd_o = rd_vec[SPC_INT];
  assign ioi_wr_o = wr_vec[SPC_INT];
  assign ioe_rd_o = rd_vec[SPC_EXT];
  assign ioe_wr_o = wr_vec[SPC_EXT];
endmodule

// File: rtl/io_space_redirector_chk.sv
module io_space_redirector_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              pfx_int_i,
  input logic              pfx_ext_i,
  input logic              insn_end_i,
  input logic              req_valid_i,
  input logic              req_we_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              ioi_rd_o,
  input logic              ioi_wr_o,
  input logic              ioe_rd_o,
  input logic              ioe_wr_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              irq_hold_o
);
  logic [5:0] stb;
  logic       seen_q;

  assign stb = {ioe_wr_o, ioe_rd_o, ioi_wr_o, ioi_rd_o, mem_wr_o, mem_rd_o};

  // One cycle out of reset before any $past of inputs is trusted.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) seen_q <= 1'b0;
    else             seen_q <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_sync_n) begin
      assert_reset_quiet_R1: assert (stb == 6'b0 && !irq_hold_o);
    end
  end

  assert_one_space_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(stb));

  assert_req_strobe_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid_i |=> $countones(stb) == 1);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid_i |=> stb == 6'b0);

  assert_addr_pass_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid_i |=> bus_addr_o == $past(req_addr_i));

  assert_data_pass_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid_i && req_we_i) |=> (bus_wdata_o == $past(req_wdata_i)
                                   && (mem_wr_o || ioi_wr_o || ioe_wr_o)));

  assert_ext_armed_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen_q && $past(pfx_ext_i) && req_valid_i) |=> (ioe_rd_o || ioe_wr_o));

  assert_boundary_clears_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen_q && $past(insn_end_i) && !$past(pfx_int_i) && !$past(pfx_ext_i)
     && req_valid_i) |=> (mem_rd_o || mem_wr_o));

  assert_priv_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen_q && $past(pfx_int_i) && !$past(pfx_ext_i) && req_valid_i && req_we_i)
    |-> irq_hold_o);
endmodule

bind io_space_redirector io_space_redirector_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .pfx_int_i   (pfx_int_i),
  .pfx_ext_i   (pfx_ext_i),
  .insn_end_i  (insn_end_i),
  .req_valid_i (req_valid_i),
  .req_we_i    (req_we_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .ioi_rd_o    (ioi_rd_o),
  .ioi_wr_o    (ioi_wr_o),
  .ioe_rd_o    (ioe_rd_o),
  .ioe_wr_o    (ioe_wr_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .irq_hold_o  (irq_hold_o)
);

// File: tb/io_space_redirector_tb_top.sv
module io_space_redirector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pfx_int_i, pfx_ext_i, insn_end_i, req_valid_i, req_we_i;
  logic [15:0] req_addr_i;
  logic [7:0]  req_wdata_i;
  logic        mem_rd_o, mem_wr_o, ioi_rd_o, ioi_wr_o, ioe_rd_o, ioe_wr_o;
  logic [15:0] bus_addr_o;
  logic [7:0]  bus_wdata_o;
  logic        irq_hold_o;

  int checks = 0;
  int bad    = 0;
  int cyc    = 0;
  bit mon_on = 1'b0;

  typedef struct {
    logic [5:0]  stb;
    logic [15:0] addr;
    logic [7:0]  data;
    bit          is_wr;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // bench model state: 0 memory, 1 internal, 2 external
  int m_space = 0;
  bit m_hold  = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  io_space_redirector dut_i (
    .clk(clk), .rst_n(rst_n), .pfx_int_i(pfx_int_i), .pfx_ext_i(pfx_ext_i),
    .insn_end_i(insn_end_i), .req_valid_i(req_valid_i), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .ioi_rd_o(ioi_rd_o),
    .ioi_wr_o(ioi_wr_o), .ioe_rd_o(ioe_rd_o), .ioe_wr_o(ioe_wr_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .irq_hold_o(irq_hold_o)
  );

  function automatic logic [5:0] obs_stb();
    return {ioe_wr_o, ioe_rd_o, ioi_wr_o, ioi_rd_o, mem_wr_o, mem_rd_o};
  endfunction

  task automatic step(input bit pi, input bit pe, input bit en, input bit rq,
                      input bit we, input logic [15:0] a, input logic [7:0] d,
                      input string tag);
    exp_t e;
    bit   exp_hold;
    @(negedge clk);
    #1;
    pfx_int_i = pi; pfx_ext_i = pe; insn_end_i = en;
    req_valid_i = rq; req_we_i = we; req_addr_i = a; req_wdata_i = d;
    if (rq) begin
      e.stb   = 6'b1 << (m_space * 2 + (we ? 1 : 0));
      e.addr  = a;
      e.data  = d;
      e.is_wr = we;
      e.due   = cyc + 1;
      e.tag   = tag;
      sb_q.push_back(e);
    end
    exp_hold = m_hold || (rq && we && m_space == 1);
    #1;
    checks++;
    if (irq_hold_o !== exp_hold) begin
      bad++;
      $display("FAIL R10 irq_hold_o (%s) actual=%b expected=%b", tag, irq_hold_o, exp_hold);
    end
    if (en) m_hold = 1'b0;
    else if (rq && we && m_space == 1) m_hold = 1'b1;
    if (pe)      m_space = 2;
    else if (pi) m_space = 1;
    else if (en) m_space = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 16'h0, 8'h0, "R8");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      logic [5:0] o;
      o = obs_stb();
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (o !== e.stb || bus_addr_o !== e.addr || (e.is_wr && bus_wdata_o !== e.data)) begin
          bad++;
          $display("FAIL %s strobes/addr/data actual=%b/%h/%h expected=%b/%h/%h",
                   e.tag, o, bus_addr_o, bus_wdata_o, e.stb, e.addr, e.data);
        end
      end else if (o !== 6'b0) begin
        checks++;
        bad++;
        $display("FAIL R8 unexpected strobe actual=%b expected=000000", o);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pfx_int_i = 0; pfx_ext_i = 0; insn_end_i = 0; req_valid_i = 0; req_we_i = 0;
    req_addr_i = '0; req_wdata_i = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (obs_stb() !== 6'b0 || irq_hold_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs actual=%b/%b expected=000000/0", obs_stb(), irq_hold_o);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (obs_stb() !== 6'b0 || irq_hold_o !== 1'b0) begin
      bad++;
      $display("FAIL R1 post-reset outputs actual=%b/%b expected=000000/0", obs_stb(), irq_hold_o);
    end
    mon_on = 1'b1;

    // R1, R2: unprefixed accesses go to memory
    step(0, 0, 0, 1, 0, 16'h1234, 8'h00, "R1");
    step(0, 0, 1, 1, 1, 16'h1235, 8'hA5, "R2");
    idle(1);

    // R3, R10: internal prefix; read does not hold, write does
    step(1, 0, 0, 0, 0, 16'h0, 8'h0, "R3");
    step(0, 0, 0, 1, 0, 16'h0085, 8'h00, "R3");
    step(0, 0, 0, 1, 1, 16'h0086, 8'h3C, "R10");
    idle(2);
    step(0, 0, 1, 0, 0, 16'h0, 8'h0, "R10");
    idle(1);

    // R4, R6, R11: external prefix, word read at 4005h/4006h, boundary on second half
    step(0, 1, 0, 0, 0, 16'h0, 8'h0, "R4");
    step(0, 0, 0, 1, 0, 16'h4005, 8'h00, "R6");
    step(0, 0, 1, 1, 0, 16'h4006, 8'h00, "R11");
    // R5: next instruction unprefixed
    step(0, 0, 0, 1, 0, 16'h4007, 8'h00, "R5");
    step(0, 0, 1, 0, 0, 16'h0, 8'h0, "R5");

    // R7: later prefix wins, both orders, then simultaneous
    step(0, 1, 0, 0, 0, 16'h0, 8'h0, "R7");
    step(1, 0, 0, 0, 0, 16'h0, 8'h0, "R7");
    step(0, 0, 1, 1, 0, 16'h0010, 8'h00, "R7");
    step(1, 0, 0, 0, 0, 16'h0, 8'h0, "R7");
    step(0, 1, 0, 0, 0, 16'h0, 8'h0, "R7");
    step(0, 0, 1, 1, 1, 16'h0011, 8'h5A, "R7");
    step(1, 1, 0, 0, 0, 16'h0, 8'h0, "R7");
    step(0, 0, 1, 1, 0, 16'h0012, 8'h00, "R7");

    // R5: prefix coincident with boundary stays armed
    step(1, 0, 1, 0, 0, 16'h0, 8'h0, "R5");
    step(0, 0, 0, 1, 0, 16'h0020, 8'h00, "R5");
    step(0, 0, 1, 0, 0, 16'h0, 8'h0, "R5");

    // R10: external write does not hold
    step(0, 1, 0, 0, 0, 16'h0, 8'h0, "R10");
    step(0, 0, 1, 1, 1, 16'hBEEF, 8'h77, "R10");
    // R10, R11: internal write on the boundary holds for that cycle only
    step(1, 0, 0, 0, 0, 16'h0, 8'h0, "R10");
    step(0, 0, 1, 1, 1, 16'h00C0, 8'hE1, "R11");
    idle(2);

    // R9: back-to-back memory writes with distinct data
    step(0, 0, 0, 1, 1, 16'hFFFF, 8'hFF, "R9");
    step(0, 0, 1, 1, 1, 16'h0000, 8'h01, "R9");
    idle(3);

    checks++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R8 missing strobes actual=%0d expected=0", sb_q.size());
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule